// File: doc/BRIEF.md
# Reset Sequencer

This block produces a system reset from three sources: a digital supply-good flag from an analog comparator, an active-low push-button input, and a shared active-low reset pin that outside logic may pull. Every reset event is stretched to a minimum length. The timeout counts in clock cycles and is set by a parameter.

Short low pulses on the supply flag and on the push-button are filtered out. A falling edge on the shared pin starts a full-length reset, even when the outside pulse is much shorter. A one-cycle request from a watchdog restarts the timeout.

The block has an active-high and an active-low reset output. It has two open-drain drive enables: one pulls the shared pin low and one drives the active-high line. A status flag shows when the block is counting out a timeout after every source has released. The pin sampler ignores the block's own drive, so the block cannot retrigger itself.

Top module: `reset_sequencer`

## Requirements
- R1: While rst_ni is low, rst_o is 1. The supply flag starts in the "not good" state, so rst_o stays 1 while supply_ok_i is low. After supply_ok_i rises, rst_o stays 1 for at least TIMEOUT_CYC cycles and falls no more than 6 cycles later than that.
- R2: If supply_ok_i stays low for SUP_GLITCH_CYC or more cycles, rst_o is 1 for the whole low period. It then stays 1 for at least TIMEOUT_CYC cycles after supply_ok_i returns high. A timeout that is already counting restarts.
- R3: A low pulse on supply_ok_i shorter than SUP_GLITCH_CYC cycles leaves rst_o at 0.
- R4: If mr_ni stays low for MR_GLITCH_CYC or more cycles, rst_o is 1 while the filtered input is low. It then stays 1 for at least TIMEOUT_CYC cycles after mr_ni returns high.
- R5: A low pulse on mr_ni shorter than MR_GLITCH_CYC cycles leaves rst_o at 0.
- R6: A high-to-low transition on rst_pin_i starts one reset of at least TIMEOUT_CYC cycles and at most TIMEOUT_CYC+6 cycles. This holds for any outside pulse width from 1 to 6 cycles.
- R7: The block's own drive on the shared pin, both when it starts and when it is released, never starts another reset. Each single event gives exactly one rising edge of rst_o.
- R8: A one-cycle wdog_req_i sampled while the block is idle makes rst_o 1 for exactly TIMEOUT_CYC cycles. A second request during that period restarts the count from its own cycle.
- R9: rst_no is always the complement of rst_o. pin_pull_o and hi_push_o always equal rst_o.
- R10: stretch_o is 1 only while rst_o is 1 and no level source (supply or push-button) is held active. After a single watchdog request, stretch_o is 1 for exactly TIMEOUT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, asynchronous |
| mr_ni | input | 1 | Push-button reset, active low, asynchronous |
| wdog_req_i | input | 1 | One-cycle watchdog reset request, synchronous |
| rst_pin_i | input | 1 | Sampled level of the shared active-low reset pin |
| rst_o | output | 1 | Reset, active high |
| rst_no | output | 1 | Reset, active low |
| pin_pull_o | output | 1 | Open-drain enable that pulls the shared pin low |
| hi_push_o | output | 1 | Open-drain enable that drives the active-high line |
| stretch_o | output | 1 | Timeout in progress with all level sources released |

## Verification
A stretch counter with the wrong value shows up at the ports as a reset of the wrong length. It becomes visible when rst_o falls, at most one timeout after the last event. A glitch filter whose count is off by one shows up as a reset after a pulse that should have been rejected, or as no reset after a pulse that is just long enough. The sweeps over pulse width cover both sides of each filter window. If the pin sampler leaks the block's own drive, rst_o rises a second time a few cycles after the first reset ends, so each run counts the rising edges of rst_o.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int SyncDepth = 2;
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import rsq_pkg::*;
  logic [SyncDepth-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < SyncDepth; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[SyncDepth-1];
endmodule

// File: rtl/rsq_low_filter.sv
// Low level passes only after GLITCH_CYC consecutive low samples; high passes at once.
module rsq_low_filter #(
  parameter int GLITCH_CYC = 4,
  parameter bit RST_OUT    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  localparam int LW = rsq_pkg::cnt_width(GLITCH_CYC);
  localparam logic [LW-1:0] LAST = LW'(GLITCH_CYC - 1);

  logic [LW-1:0] low_cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      out_q     <= RST_OUT;
    end else if (in_i) begin
      low_cnt_q <= '0;
      out_q     <= 1'b1;
    end else if (low_cnt_q == LAST) begin
      out_q     <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign out_o = out_q;

  assert_filter_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_q) |-> ($past(low_cnt_q) == LAST && !$past(in_i)));
endmodule

// File: rtl/rsq_pin_edge.sv
// Falling-edge detect on the synchronized shared pin, blind while own drive is in flight.
module rsq_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic own_drv_i,
  output logic edge_o
);
  import rsq_pkg::*;
  logic [SyncDepth-1:0] drv_hist_q;
  logic                 lvl_q;
  logic                 mask;
  logic                 lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_hist_q <= '1;
      lvl_q      <= 1'b1;
    end else begin
      drv_hist_q <= {drv_hist_q[SyncDepth-2:0], own_drv_i};
      lvl_q      <= lvl;
    end
  end

  assign mask   = own_drv_i | (|drv_hist_q);
  assign lvl    = pin_s_i | mask;
  assign edge_o = lvl_q & ~lvl;

  assert_no_self_trigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> !own_drv_i && !$past(own_drv_i));
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic trig_i,
  output logic active_o,
  output logic stretch_o
);
  localparam int CW = rsq_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= FULL;
      hold_q <= 1'b1;
    end else begin
      hold_q <= hold_i;
      if (hold_i || trig_i)  cnt_q <= FULL;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o  = (cnt_q != '0);
  assign stretch_o = active_o & ~hold_q;

  assert_hold_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == FULL);
  assert_countdown_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !trig_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int TIMEOUT_CYC    = 50_000_000,
  parameter int SUP_GLITCH_CYC = 8,
  parameter int MR_GLITCH_CYC  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  input  logic wdog_req_i,
  input  logic rst_pin_i,
  output logic rst_o,
  output logic rst_no,
  output logic pin_pull_o,
  output logic hi_push_o,
  output logic stretch_o
);
  logic sup_s, mr_s, pin_s;
  logic sup_f, mr_f;
  logic pin_edge;
  logic active;
  logic hold;

  rsq_sync #(.RST_VAL(1'b0)) i_sync_sup (.clk_i, .rst_ni, .d_i(supply_ok_i), .q_o(sup_s));
  rsq_sync #(.RST_VAL(1'b1)) i_sync_mr  (.clk_i, .rst_ni, .d_i(mr_ni),       .q_o(mr_s));
  rsq_sync #(.RST_VAL(1'b1)) i_sync_pin (.clk_i, .rst_ni, .d_i(rst_pin_i),   .q_o(pin_s));

  rsq_low_filter #(.GLITCH_CYC(SUP_GLITCH_CYC), .RST_OUT(1'b0)) i_flt_sup (
    .clk_i, .rst_ni, .in_i(sup_s), .out_o(sup_f));
  rsq_low_filter #(.GLITCH_CYC(MR_GLITCH_CYC), .RST_OUT(1'b1)) i_flt_mr (
    .clk_i, .rst_ni, .in_i(mr_s), .out_o(mr_f));

  rsq_pin_edge i_pin_edge (
    .clk_i, .rst_ni, .pin_s_i(pin_s), .own_drv_i(active), .edge_o(pin_edge));

  assign hold = ~sup_f | ~mr_f;

  rsq_stretch #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_stretch (
    .clk_i, .rst_ni, .hold_i(hold), .trig_i(pin_edge | wdog_req_i),
    .active_o(active), .stretch_o(stretch_o));

  assign rst_o      = active;
  assign rst_no     = ~active;
  assign pin_pull_o = active;
  assign hi_push_o  = active;

  assert_wdog_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_req_i |=> rst_o);
  assert_pin_edge_resets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_edge |=> rst_o && pin_pull_o);
  assert_supply_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_f |=> rst_o);
  assert_stretch_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stretch_o |-> rst_o && !$past(hold));
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  localparam int T   = 40;
  localparam int SG  = 3;
  localparam int MG  = 5;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok = 1'b0, mr_n = 1'b1, wdog = 1'b0, ext_low = 1'b0;
  logic rst, rst_n_o, pin_pull, hi_push, stretch;
  logic pin;
  int   errors = 0, checks = 0;

  assign pin = ~(ext_low | pin_pull);

  always #2 clk = ~clk;

  reset_sequencer #(.TIMEOUT_CYC(T), .SUP_GLITCH_CYC(SG), .MR_GLITCH_CYC(MG)) i_reset_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup_ok), .mr_ni(mr_n), .wdog_req_i(wdog),
    .rst_pin_i(pin), .rst_o(rst), .rst_no(rst_n_o), .pin_pull_o(pin_pull),
    .hi_push_o(hi_push), .stretch_o(stretch));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 supply low, 1 manual low, 2 shared pin low, 3 watchdog, 4 double watchdog
  task automatic run(input int kind, input int width, input int win,
                     output int hi, output int rises, output int strc, output int bad);
    logic prev = 1'b0;
    hi = 0; rises = 0; strc = 0; bad = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (rst) hi++;
      if (rst && !prev) rises++;
      prev = rst;
      if (stretch) strc++;
      if (stretch && !rst) bad++;
      if (rst_n_o !== ~rst || pin_pull !== rst || hi_push !== rst) bad++;
      sup_ok  = !(kind == 0 && i < width);
      mr_n    = !(kind == 1 && i < width);
      ext_low = (kind == 2 && i < width);
      wdog    = ((kind == 3 || kind == 4) && i == 0) || (kind == 4 && i == width);
    end
  endtask

  initial begin
    int hi, rises, strc, bad;
    repeat (3) @(negedge clk);
    chk(rst === 1'b1 && rst_n_o === 1'b0, "R1 reset state", rst, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(rst === 1'b1, "R1 supply low holds", rst, 1);
    sup_ok = 1'b1;
    hi = 0;
    for (int i = 0; i < T + 20; i++) begin
      @(negedge clk);
      if (rst) hi++;
    end
    chk(hi >= T && hi <= T + LAT, "R1 power-up stretch", hi, T);
    chk(rst === 1'b0, "R1 released", rst, 0);

    for (int w = 1; w <= SG + 3; w++) begin
      run(0, w, w + T + 20, hi, rises, strc, bad);
      if (w < SG) chk(hi == 0, "R3 supply glitch rejected", hi, 0);
      else chk(hi >= T + w - SG && hi <= T + w + LAT && rises == 1, "R2 supply low reset", hi, T + w);
      chk(bad == 0, "R9 complement", bad, 0);
    end

    for (int w = 1; w <= MG + 3; w++) begin
      run(1, w, w + T + 20, hi, rises, strc, bad);
      if (w < MG) chk(hi == 0, "R5 manual glitch rejected", hi, 0);
      else begin
        chk(hi >= T + w - MG && hi <= T + w + LAT && rises == 1, "R4 manual reset", hi, T + w);
        chk(bad == 0 && strc >= T - 1 && strc <= T, "R10 stretch flag", strc, T);
      end
    end

    for (int w = 1; w <= 6; w++) begin
      run(2, w, T + 30, hi, rises, strc, bad);
      chk(hi >= T && hi <= T + LAT, "R6 pin edge full reset", hi, T);
      chk(rises == 1, "R7 no self retrigger", rises, 1);
      chk(bad == 0, "R9 outputs agree", bad, 0);
    end

    run(3, 0, T + 30, hi, rises, strc, bad);
    chk(hi == T, "R8 watchdog exact length", hi, T);
    chk(rises == 1, "R7 watchdog single reset", rises, 1);
    chk(strc == T && bad == 0, "R10 stretch after watchdog", strc, T);

    run(4, T / 2, 2 * T + 30, hi, rises, strc, bad);
    chk(hi == T / 2 + T, "R8 watchdog restart", hi, T / 2 + T);

    // supply drop during a running timeout restarts it
    run(3, 0, T / 2, hi, rises, strc, bad);
    run(0, SG + 4, SG + 4 + T + 20, hi, rises, strc, bad);
    chk(hi >= T + 4 && hi <= T + SG + 4 + LAT, "R2 restart during timeout", hi, T + SG + 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule